// File: doc/BRIEF.md
# Receive Frame Acceptance and Status Unit

This unit follows an incoming Ethernet frame byte by byte after its preamble and start delimiter have been removed. It counts the bytes, captures the verdict of an external destination-address recognizer when the sixth byte arrives, and tells the receive buffer whether to keep or drop the frame. The keep decision waits until a 64-byte collision window has been received, so collision fragments are never kept.

When the frame ends, the unit emits one 32-bit status word. The word holds the byte count, the recognizer's address-type flags and the error flags reported by neighbouring logic (CRC, overrun, truncation, non-octet ending). Frames longer than a programmable maximum are never cut short. They are marked too long and raise a babbling-receiver event. Two interrupt sources, frame done and babble, are held in sticky status bits that are cleared by writing one, and each source is gated to its output by an enable bit.

Top module: `rx_frame_gate`

## Requirements
- R1: One cycle after the cycle in which `frame_end` is high, `stat_vld` pulses for one cycle and `stat_word[10:0]` holds the number of bytes taken in that frame. A byte strobed in the same cycle as `frame_end` is counted.
- R2: `commit` pulses once, in the cycle after the 64th byte is taken, when the address verdict captured with the sixth byte was a hit.
- R3: Every frame gets exactly one of `commit` and `discard`. A frame that misses address recognition is discarded in the cycle after its 64th byte. A frame that ends before its 64th byte is discarded in the cycle after `frame_end`.
- R4: The recognizer inputs are sampled in the cycle of the sixth byte strobe. Status bit 23 reports a miss (not hit), bit 22 broadcast and bit 21 multicast. All three bits are 0 for frames shorter than 6 bytes.
- R5: The error inputs sampled with `frame_end` appear in the status word as truncated at bit 16, overrun at bit 17, CRC error at bit 18 and non-octet at bit 19.
- R6: Status bit 20 (too long) is set when the byte count exceeds the maximum-length register. The length field still reports the full count. The register is 11 bits wide, resets to 1518 and is loaded by `max_wr`.
- R7: `irq_stat[1]` (babble) is set in the cycle after the byte that first takes the count above the maximum. `irq_stat[0]` (frame done) is set together with `stat_vld`.
- R8: `irq_stat` bits stay set until a one is written to the matching bit of `irq_clr`. When a set and a clear fall in the same cycle, the set wins.
- R9: `irq_frame` and `irq_babble` equal `irq_stat[0]` and `irq_stat[1]`, each ANDed with its enable bit. The enables reset to 0 and are loaded by `ien_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | One frame byte taken this cycle |
| frame_end | input | 1 | Frame finishes this cycle |
| addr_hit | input | 1 | Recognizer accepts the destination address |
| addr_bcast | input | 1 | Destination is broadcast |
| addr_mcast | input | 1 | Destination is a group address |
| crc_err | input | 1 | CRC check failed, sampled at end |
| ovr_err | input | 1 | Buffer overrun, sampled at end |
| trunc_err | input | 1 | Frame truncated, sampled at end |
| odd_bits | input | 1 | Frame did not end on an octet, sampled at end |
| max_wr | input | 1 | Load maximum-length register |
| max_wdata | input | 11 | New maximum length |
| ien_wr | input | 1 | Load interrupt enables |
| ien_wdata | input | 2 | New enables (bit 0 frame, bit 1 babble) |
| irq_clr | input | 2 | Write-one-to-clear for interrupt status |
| commit | output | 1 | Buffer may keep the frame |
| discard | output | 1 | Buffer must drop the frame |
| stat_vld | output | 1 | Status word valid |
| stat_word | output | 32 | Frame status and length |
| irq_stat | output | 2 | Sticky interrupt status |
| irq_frame | output | 1 | Masked frame-done interrupt |
| irq_babble | output | 1 | Masked babble interrupt |

## Verification
Two pairs of functions can fall in the same cycle. The first is the end of a frame and the 64th byte. A frame is ended with `frame_end` driven together with its 64th byte strobe, and the bench expects `commit` and `stat_vld` in the same cycle with no `discard`. The second is a frame-done set and a software clear. `irq_clr` is driven in the cycle of `frame_end`, and the frame bit must still read set afterwards. A clear written on its own must then remove it.

// File: rtl/rxfg_pkg.sv
package rxfg_pkg;
    localparam int STAT_W  = 32;
    localparam int B_TRUNC = 16;
    localparam int B_OVR   = 17;
    localparam int B_CRC   = 18;
    localparam int B_NOB   = 19;
    localparam int B_LONG  = 20;
    localparam int B_MC    = 21;
    localparam int B_BC    = 22;
    localparam int B_MISS  = 23;
    localparam int IRQ_N   = 2;
    localparam int IRQ_FRM = 0;
    localparam int IRQ_BAB = 1;

    typedef struct packed {
        logic hit;
        logic bc;
        logic mc;
    } verdict_t;
endpackage

// File: rtl/rxfg_len_track.sv
module rxfg_len_track #(
    parameter int LEN_W       = 11,
    parameter int MAX_LEN_RST = 1518
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic             frame_end,
    input  logic             max_wr,
    input  logic [LEN_W-1:0] max_wdata,
    output logic [LEN_W-1:0] cnt_q,
    output logic [LEN_W-1:0] len_now,
    output logic             long_now,
    output logic             long_rise
);
    localparam logic [LEN_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic             lng;
        logic [LEN_W-1:0] mx;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        len_now   = (byte_vld && st_q.cnt != CNT_TOP) ? st_q.cnt + 1'b1 : st_q.cnt;
        long_now  = st_q.lng | (len_now > st_q.mx);
        long_rise = long_now & ~st_q.lng;
        st_d.cnt  = frame_end ? '0 : len_now;
        st_d.lng  = frame_end ? 1'b0 : long_now;
        if (max_wr) begin
            st_d.mx = max_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.lng <= 1'b0;
            st_q.mx  <= LEN_W'(MAX_LEN_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;

    AST_LONG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(long_now) && !$past(frame_end)) |-> long_now) // R6
        else $error("too-long mark dropped mid-frame");
endmodule

// File: rtl/rxfg_irq.sv
module rxfg_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic         en_wr,
    input  logic [N-1:0] en_wdata,
    output logic [N-1:0] stat,
    output logic [N-1:0] irq
);
    typedef struct packed {
        logic [N-1:0] stat;
        logic [N-1:0] en;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.stat = (st_q.stat & ~clr) | set;
        if (en_wr) begin
            st_d.en = en_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_out
        assign irq[i] = st_q.stat[i] & st_q.en[i];
    end
    assign stat = st_q.stat;

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat) & ~$past(clr) & ~stat) == '0) // R8
        else $error("status bit fell without clear");
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(set) & ~stat) == '0) // R8
        else $error("set event lost");
endmodule

// File: rtl/rx_frame_gate.sv
module rx_frame_gate #(
    parameter int LEN_W       = 11,
    parameter int ADDR_BYTES  = 6,
    parameter int WIN_BYTES   = 64,
    parameter int MAX_LEN_RST = 1518
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic             frame_end,
    input  logic             addr_hit,
    input  logic             addr_bcast,
    input  logic             addr_mcast,
    input  logic             crc_err,
    input  logic             ovr_err,
    input  logic             trunc_err,
    input  logic             odd_bits,
    input  logic             max_wr,
    input  logic [LEN_W-1:0] max_wdata,
    input  logic             ien_wr,
    input  logic [1:0]       ien_wdata,
    input  logic [1:0]       irq_clr,
    output logic             commit,
    output logic             discard,
    output logic             stat_vld,
    output logic [31:0]      stat_word,
    output logic [1:0]       irq_stat,
    output logic             irq_frame,
    output logic             irq_babble
);
    import rxfg_pkg::*;

    localparam logic [LEN_W-1:0] ADDR_LAST = LEN_W'(ADDR_BYTES - 1);
    localparam logic [LEN_W-1:0] WIN_LAST  = LEN_W'(WIN_BYTES - 1);
    localparam logic [LEN_W-1:0] WIN_LEN   = LEN_W'(WIN_BYTES);
    localparam logic [LEN_W-1:0] ADDR_LEN  = LEN_W'(ADDR_BYTES);

    typedef struct packed {
        logic              vdone;
        verdict_t          vr;
        logic              decided;
        logic              commit;
        logic              discard;
        logic              stat_vld;
        logic [STAT_W-1:0] word;
    } st_t;

    st_t st_q, st_d;

    logic [LEN_W-1:0] cnt_q, len_now;
    logic             long_now, long_rise;
    logic [IRQ_N-1:0] irq_set, irq_out;

    rxfg_len_track #(.LEN_W(LEN_W), .MAX_LEN_RST(MAX_LEN_RST)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .frame_end (frame_end),
        .max_wr    (max_wr),
        .max_wdata (max_wdata),
        .cnt_q     (cnt_q),
        .len_now   (len_now),
        .long_now  (long_now),
        .long_rise (long_rise)
    );

    logic     sixth, win, vd_now, accept;
    verdict_t vr_now;

    always_comb begin
        st_d          = st_q;
        st_d.commit   = 1'b0;
        st_d.discard  = 1'b0;
        st_d.stat_vld = 1'b0;

        sixth = byte_vld && (cnt_q == ADDR_LAST);
        win   = byte_vld && (cnt_q == WIN_LAST) && !st_q.decided;

        vd_now = st_q.vdone | sixth;
        vr_now = st_q.vr;
        if (sixth) begin
            vr_now.hit = addr_hit;
            vr_now.bc  = addr_bcast;
            vr_now.mc  = addr_mcast;
        end
        accept = vd_now & vr_now.hit;

        st_d.vdone = vd_now;
        st_d.vr    = vr_now;
        if (win) begin
            st_d.decided = 1'b1;
            st_d.commit  = accept;
            st_d.discard = ~accept;
        end

        if (frame_end) begin
            st_d.stat_vld         = 1'b1;
            st_d.word             = '0;
            st_d.word[LEN_W-1:0]  = len_now;
            st_d.word[B_TRUNC]    = trunc_err;
            st_d.word[B_OVR]      = ovr_err;
            st_d.word[B_CRC]      = crc_err;
            st_d.word[B_NOB]      = odd_bits;
            st_d.word[B_LONG]     = long_now;
            st_d.word[B_MC]       = vd_now & vr_now.mc;
            st_d.word[B_BC]       = vd_now & vr_now.bc;
            st_d.word[B_MISS]     = vd_now & ~vr_now.hit;
            if (!st_q.decided && !win) begin
                st_d.discard = 1'b1;
            end
            st_d.vdone   = 1'b0;
            st_d.vr      = '0;
            st_d.decided = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        irq_set          = '0;
        irq_set[IRQ_FRM] = frame_end;
        irq_set[IRQ_BAB] = long_rise;
    end

    rxfg_irq #(.N(IRQ_N)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (irq_set),
        .clr      (irq_clr),
        .en_wr    (ien_wr),
        .en_wdata (ien_wdata),
        .stat     (irq_stat),
        .irq      (irq_out)
    );

    assign commit     = st_q.commit;
    assign discard    = st_q.discard;
    assign stat_vld   = st_q.stat_vld;
    assign stat_word  = st_q.word;
    assign irq_frame  = irq_out[IRQ_FRM];
    assign irq_babble = irq_out[IRQ_BAB];

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && discard)) // R3
        else $error("commit and discard together");
    AST_COMMIT_AT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(byte_vld) && $past(cnt_q) == WIN_LAST)) // R2
        else $error("commit outside collision window edge");
    AST_STAT_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> $past(frame_end)) // R1
        else $error("status without frame end");
    AST_RUNT_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vld && discard && !stat_word[B_MISS]) |-> (stat_word[LEN_W-1:0] < WIN_LEN)) // R3
        else $error("end discard on a full-size hit frame");
    AST_SHORT_NO_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vld && stat_word[LEN_W-1:0] < ADDR_LEN) |-> (stat_word[B_MISS:B_MC] == 3'b000)) // R4
        else $error("address flags on a frame without destination");
endmodule

// File: tb/tb_rx_frame_gate.sv
module tb_rx_frame_gate;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 0, frame_end = 0;
    logic        addr_hit = 0, addr_bcast = 0, addr_mcast = 0;
    logic        crc_err = 0, ovr_err = 0, trunc_err = 0, odd_bits = 0;
    logic        max_wr = 0;
    logic [10:0] max_wdata = '0;
    logic        ien_wr = 0;
    logic [1:0]  ien_wdata = '0;
    logic [1:0]  irq_clr = '0;
    logic        commit, discard, stat_vld, irq_frame, irq_babble;
    logic [31:0] stat_word;
    logic [1:0]  irq_stat;

    rx_frame_gate dut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .frame_end(frame_end),
        .addr_hit(addr_hit), .addr_bcast(addr_bcast), .addr_mcast(addr_mcast),
        .crc_err(crc_err), .ovr_err(ovr_err), .trunc_err(trunc_err), .odd_bits(odd_bits),
        .max_wr(max_wr), .max_wdata(max_wdata), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
        .irq_clr(irq_clr), .commit(commit), .discard(discard), .stat_vld(stat_vld),
        .stat_word(stat_word), .irq_stat(irq_stat), .irq_frame(irq_frame),
        .irq_babble(irq_babble)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [10:0] len;
        logic hit, bc, mc, crc, ovr, trn, nob, endl;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{11'd3,    1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{11'd6,    1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{11'd40,   1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{11'd64,   1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{11'd64,   1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{11'd64,   1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{11'd100,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        '{11'd1518, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{11'd1519, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{11'd63,   1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    int errors = 0, checks = 0;
    int mx = 1518;
    int sent, n_c, n_d, c_at, d_at;
    bit done = 0;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input vec_t v);
        logic [31:0] w = '0;
        w[10:0] = v.len;
        if (v.len >= 6) begin
            w[23] = ~v.hit;
            w[22] = v.bc;
            w[21] = v.mc;
        end
        w[16] = v.trn;
        w[17] = v.ovr;
        w[18] = v.crc;
        w[19] = v.nob;
        w[20] = (int'(v.len) > mx);
        return w;
    endfunction

    task automatic observe(input int len);
        if (commit) begin n_c++; c_at = sent; end
        if (discard) begin n_d++; d_at = sent; end
        if (len > mx && sent == mx) chk(irq_stat[1] == 1'b0, "R7 babble before limit", irq_stat[1], 0);
        if (len > mx && sent == mx + 1) chk(irq_stat[1] == 1'b1, "R7 babble after limit", irq_stat[1], 1);
    endtask

    task automatic end_inputs(input vec_t v, input logic [1:0] clr_end);
        frame_end = 1'b1;
        crc_err = v.crc; ovr_err = v.ovr; trunc_err = v.trn; odd_bits = v.nob;
        irq_clr = clr_end;
    endtask

    task automatic send_frame(input vec_t v, input logic [1:0] clr_end);
        logic [31:0] ew;
        int len;
        bit exp_c;
        len = int'(v.len);
        n_c = 0; n_d = 0; c_at = -1; d_at = -1; sent = 0;
        addr_hit = v.hit; addr_bcast = v.bc; addr_mcast = v.mc;
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            observe(len);
            byte_vld = 1'b1;
            sent = i;
            if (v.endl && i == len) end_inputs(v, clr_end);
        end
        if (!v.endl) begin
            @(negedge clk);
            observe(len);
            byte_vld = 1'b0;
            end_inputs(v, clr_end);
        end
        @(negedge clk);
        observe(len);
        byte_vld = 0; frame_end = 0; irq_clr = '0;
        crc_err = 0; ovr_err = 0; trunc_err = 0; odd_bits = 0;
        ew = exp_word(v);
        chk(stat_vld == 1'b1, "R1 status pulse", stat_vld, 1);
        chk(stat_word[10:0] == ew[10:0], "R1 length field", stat_word[10:0], ew[10:0]);
        chk(stat_word[23:21] == ew[23:21], "R4 address flags", stat_word[23:21], ew[23:21]);
        chk(stat_word[19:16] == ew[19:16], "R5 error flags", stat_word[19:16], ew[19:16]);
        chk(stat_word[20] == ew[20], "R6 too-long flag", stat_word[20], ew[20]);
        chk(stat_word == ew, "R1 whole status word", stat_word, ew);
        exp_c = (len >= 64) && v.hit;
        if (exp_c) begin
            chk(n_c == 1 && n_d == 0, "R2 one commit", n_c * 16 + n_d, 16);
            chk(c_at == 64, "R2 commit byte", c_at, 64);
        end else begin
            chk(n_d == 1 && n_c == 0, "R3 one discard", n_d * 16 + n_c, 16);
            chk(d_at == (len < 64 ? len : 64), "R3 discard byte", d_at, (len < 64 ? len : 64));
        end
        chk(irq_stat[0] == 1'b1, "R7 frame status set", irq_stat[0], 1);
        chk(irq_stat[1] == (len > mx), "R7 babble status", irq_stat[1], (len > mx));
    endtask

    task automatic clear_irq(input logic [1:0] m);
        @(negedge clk);
        irq_clr = m;
        @(negedge clk);
        irq_clr = '0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(commit == 0 && discard == 0, "R3 reset outcome idle", {commit, discard}, 0);
        chk(stat_vld == 0 && stat_word == 0, "R1 reset status idle", stat_word, 0);
        chk(irq_stat == 0 && irq_frame == 0 && irq_babble == 0, "R9 reset irq", irq_stat, 0);

        for (int k = 0; k < NV; k++) begin
            send_frame(VECS[k], 2'b00);
            clear_irq(2'b11);
            chk(irq_stat == 2'b00, "R8 clear after frame", irq_stat, 0);
        end

        // R9: enables at reset hide the frame interrupt
        send_frame('{11'd10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, 2'b00);
        chk(irq_frame == 1'b0, "R9 masked frame irq", irq_frame, 0);
        @(negedge clk);
        ien_wr = 1'b1; ien_wdata = 2'b11;
        @(negedge clk);
        ien_wr = 1'b0;
        chk(irq_frame == 1'b1, "R9 enabled frame irq", irq_frame, 1);
        chk(irq_babble == 1'b0, "R9 babble idle", irq_babble, 0);

        // R8: clear in the same cycle as a new frame-done set
        send_frame('{11'd12, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, 2'b01);
        chk(irq_stat[0] == 1'b1, "R8 set beats clear", irq_stat[0], 1);
        clear_irq(2'b01);
        chk(irq_stat[0] == 1'b0, "R8 lone clear", irq_stat[0], 0);
        chk(irq_frame == 1'b0, "R9 output follows clear", irq_frame, 0);

        // R6: programmed maximum of 100
        @(negedge clk);
        max_wr = 1'b1; max_wdata = 11'd100;
        @(negedge clk);
        max_wr = 1'b0;
        mx = 100;
        send_frame('{11'd100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, 2'b00);
        clear_irq(2'b11);
        send_frame('{11'd101, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, 2'b00);
        chk(irq_babble == 1'b1, "R9 babble output", irq_babble, 1);
        chk(irq_stat[1] == 1'b1, "R8 babble held", irq_stat[1], 1);
        clear_irq(2'b10);
        chk(irq_stat == 2'b01, "R8 selective clear", irq_stat, 1);

        done = 1;
        summary();
        $finish;
    end
endmodule